// File: doc/BRIEF.md
# Quick Operand Expander

This block turns the short operand fields packed into an instruction word into full 64-bit operand values for the execute stage. It decodes four field kinds: a 4-bit signed immediate, a 4-bit signed offset scaled by the operand size in bytes, a 4-bit unsigned scale factor, and an 8-bit signed immediate or offset. The 8-bit kind is never scaled.

The operand value comes from one of three places. It can be the decoded quick field, a sign-extended extension word of 16, 32 or 64 bits, or an implied zero. The choice depends on the extension-size code and on whether the quick bits already carry the other operand of the instruction. A final mask cuts immediates to the operation width and offsets to the machine pointer width. The block also raises a flag when quick bits that should be coded as zero are nonzero. The block is purely combinational. The decode stage drives it, and the register file and address adder use its result.

Top module: `qx_quick_expand`

## Requirements
- R1: Kind 000 (signed 4-bit immediate) takes bits [3:0] of the field. Code 0000 gives +8, codes 0001..0111 give +1..+7 and codes 1000..1111 give -8..-1. Field bits [7:4] have no effect.
- R2: Kind 010 (scale factor) gives 16 for code 0000 and the plain code value otherwise, always in 1..16. The extension code, the extension value and the busy input have no effect, and the flag stays low.
- R3: Kind 001 (scaled offset) is the R1 value multiplied by the operand byte count of the size code: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8, 100 gives PTR_W/8, 101 gives 16, 110 gives 32 and 111 gives 64.
- R4: Kinds 011 (8-bit immediate) and 100 (8-bit offset) give the sign-extended field [7:0], from -128 to +127. These kinds are never scaled.
- R5: With extension code 00, the output is the quick value when the busy input is 0, and zero when the busy input is 1.
- R6: Extension codes 01, 10 and 11 select the low 16, 32 or 64 bits of the extension value, sign-extended. This value replaces the quick value whatever the busy input is.
- R7: Immediate kinds (000, 011) keep the low 8, 16, 32 or 64 bits for size codes 000..011 and the low PTR_W bits for code 100. Codes 101..111 keep all 64 bits. The masked-off bits read zero.
- R8: Offset kinds (001, 100) keep the low PTR_W bits, and the bits above read zero.
- R9: bad_quick_o is 1 exactly when the extension code is nonzero, the busy input is 0, the kind is 000, 001, 011 or 100, and the field bits that kind uses ([3:0] or [7:0]) are nonzero.
- R10: Reserved kinds 101..111 give a zero value, and the flag stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fld_i | input | 8 | Quick field bits from the instruction |
| kind_i | input | 3 | Field kind selector |
| size_i | input | 3 | Operation size / register domain code |
| ext_code_i | input | 2 | Extension word size code |
| ext_val_i | input | 64 | Extension word, right-aligned |
| quick_busy_i | input | 1 | Quick bits already carry the other operand |
| val_o | output | 64 | Expanded operand value |
| bad_quick_o | output | 1 | Nonzero quick bits where zero is required |

## Verification
Two functions can act on the same input set: extension selection and the quick-bits-must-be-zero flag. A nonzero quick field together with a nonzero extension code drives both at once. The bench checks that the value follows the extension word while the flag rises. It then repeats the case with the busy input set and with only unused field bits nonzero, and expects the flag to stay low. Sign extension and the final width mask also meet when a negative extension or a negative scaled offset is cut to a narrow size or to the pointer width. The bench judges those cases against values it computes bit by bit.

// File: rtl/qx_pkg.sv
package qx_pkg;
  localparam int VAL_W = 64;

  typedef enum logic [2:0] {
    QK_IMM4 = 3'd0,
    QK_OFF4 = 3'd1,
    QK_SCL4 = 3'd2,
    QK_IMM8 = 3'd3,
    QK_OFF8 = 3'd4
  } qkind_e;

  typedef enum logic [1:0] {
    XS_NONE = 2'd0,
    XS_16   = 2'd1,
    XS_32   = 2'd2,
    XS_64   = 2'd3
  } xsize_e;

  function automatic int ptr_bytes_log(input int ptr_w);
    return (ptr_w == 16) ? 1 : (ptr_w == 32) ? 2 : 3;
  endfunction
endpackage

// File: rtl/qx_quick_decode.sv
module qx_quick_decode
  import qx_pkg::*;
#(
  parameter int PTR_W = 32,
  localparam int PLOG = ptr_bytes_log(PTR_W)
) (
  input  logic [7:0]       fld,
  input  logic [2:0]       kind,
  input  logic [2:0]       size,
  output logic [VAL_W-1:0] q_val,
  output logic             q_used_nz,
  output logic             is_off,
  output logic             is_scl,
  output logic             is_valid
);
  logic [VAL_W-1:0] s4, s8, u4, off4;
  int unsigned      sh;

  // size code -> log2 of the operand byte count
  always_comb begin
    case (size)
      3'd0:    sh = 0;
      3'd1:    sh = 1;
      3'd2:    sh = 2;
      3'd3:    sh = 3;
      3'd4:    sh = PLOG;
      3'd5:    sh = 4;
      3'd6:    sh = 5;
      default: sh = 6;
    endcase
  end

  always_comb begin
    s4   = (fld[3:0] == 4'd0) ? VAL_W'(8) : {{(VAL_W-4){fld[3]}}, fld[3:0]};
    u4   = (fld[3:0] == 4'd0) ? VAL_W'(16) : VAL_W'(fld[3:0]);
    s8   = {{(VAL_W-8){fld[7]}}, fld};
    off4 = s4 << sh;
  end

  always_comb begin
    q_val     = '0;
    q_used_nz = 1'b0;
    is_off    = 1'b0;
    is_scl    = 1'b0;
    is_valid  = 1'b1;
    case (kind)
      QK_IMM4: begin q_val = s4;   q_used_nz = |fld[3:0]; end
      QK_OFF4: begin q_val = off4; q_used_nz = |fld[3:0]; is_off = 1'b1; end
      QK_SCL4: begin q_val = u4;   is_scl = 1'b1; end
      QK_IMM8: begin q_val = s8;   q_used_nz = |fld; end
      QK_OFF8: begin q_val = s8;   q_used_nz = |fld; is_off = 1'b1; end
      default: is_valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/qx_ext_select.sv
module qx_ext_select
  import qx_pkg::*;
(
  input  logic [1:0]       ext_code,
  input  logic [VAL_W-1:0] ext_val,
  input  logic             busy,
  input  logic             is_scl,
  input  logic [VAL_W-1:0] q_val,
  output logic [VAL_W-1:0] raw
);
  always_comb begin
    if (is_scl) begin
      raw = q_val;
    end else begin
      case (ext_code)
        XS_16:   raw = {{(VAL_W-16){ext_val[15]}}, ext_val[15:0]};
        XS_32:   raw = {{(VAL_W-32){ext_val[31]}}, ext_val[31:0]};
        XS_64:   raw = ext_val;
        default: raw = busy ? '0 : q_val;
      endcase
    end
  end
endmodule

// File: rtl/qx_width_mask.sv
module qx_width_mask
  import qx_pkg::*;
#(
  parameter int PTR_W = 32
) (
  input  logic [2:0]       size,
  input  logic             is_off,
  input  logic             is_scl,
  input  logic [VAL_W-1:0] raw,
  output logic [VAL_W-1:0] masked
);
  int unsigned keep_w;

  always_comb begin
    if (is_scl) begin
      keep_w = VAL_W;
    end else if (is_off) begin
      keep_w = PTR_W;
    end else begin
      case (size)
        3'd0:    keep_w = 8;
        3'd1:    keep_w = 16;
        3'd2:    keep_w = 32;
        3'd4:    keep_w = PTR_W;
        default: keep_w = VAL_W;
      endcase
    end
  end

  always_comb begin
    if (keep_w >= VAL_W) masked = raw;
    else                 masked = raw & ((VAL_W'(1) << keep_w) - VAL_W'(1));
  end
endmodule

// File: rtl/qx_quick_expand.sv
module qx_quick_expand
  import qx_pkg::*;
#(
  parameter int PTR_W = 32
) (
  input  logic [7:0]  fld_i,
  input  logic [2:0]  kind_i,
  input  logic [2:0]  size_i,
  input  logic [1:0]  ext_code_i,
  input  logic [63:0] ext_val_i,
  input  logic        quick_busy_i,
  output logic [63:0] val_o,
  output logic        bad_quick_o
);
  logic [VAL_W-1:0] q_val, raw, masked;
  logic             q_used_nz, is_off, is_scl, is_valid;

  qx_quick_decode #(.PTR_W(PTR_W)) u_dec (
    .fld(fld_i), .kind(kind_i), .size(size_i), .q_val(q_val),
    .q_used_nz(q_used_nz), .is_off(is_off), .is_scl(is_scl), .is_valid(is_valid)
  );

  qx_ext_select u_sel (
    .ext_code(ext_code_i), .ext_val(ext_val_i), .busy(quick_busy_i),
    .is_scl(is_scl), .q_val(q_val), .raw(raw)
  );

  qx_width_mask #(.PTR_W(PTR_W)) u_msk (
    .size(size_i), .is_off(is_off), .is_scl(is_scl), .raw(raw), .masked(masked)
  );

  assign val_o       = is_valid ? masked : '0;
  assign bad_quick_o = is_valid && q_used_nz && (ext_code_i != XS_NONE) && !quick_busy_i;
endmodule

// File: rtl/qx_quick_expand_chk.sv
module qx_quick_expand_chk #(
  parameter int PTR_W = 32
) (
  input logic [7:0]  fld_i,
  input logic [2:0]  kind_i,
  input logic [2:0]  size_i,
  input logic [1:0]  ext_code_i,
  input logic [63:0] ext_val_i,
  input logic        quick_busy_i,
  input logic [63:0] val_o,
  input logic        bad_quick_o
);
  always_comb begin
    // R2
    scale_range_chk: assert (kind_i != 3'd2 || (val_o >= 64'd1 && val_o <= 64'd16))
      else $error("scale factor out of range");
    // R5
    busy_zero_chk: assert (!(ext_code_i == 2'd0 && quick_busy_i && kind_i != 3'd2) || val_o == 64'd0)
      else $error("busy quick field must yield zero");
    // R7
    byte_imm_width_chk: assert (!((kind_i == 3'd0 || kind_i == 3'd3) && size_i == 3'd0) || (val_o >> 8) == 64'd0)
      else $error("byte immediate wider than 8 bits");
    // R8
    ptr_off_width_chk: assert (!(kind_i == 3'd1 || kind_i == 3'd4) || (val_o >> PTR_W) == 64'd0)
      else $error("offset wider than pointer");
    // R9
    bad_flag_cond_chk: assert (!bad_quick_o || (ext_code_i != 2'd0 && !quick_busy_i && kind_i != 3'd2 && fld_i != 8'd0))
      else $error("flag raised without cause");
    // R10
    reserved_kind_chk: assert (kind_i <= 3'd4 || (val_o == 64'd0 && !bad_quick_o))
      else $error("reserved kind produced output");
  end
endmodule

bind qx_quick_expand qx_quick_expand_chk #(.PTR_W(PTR_W)) u_chk (
  .fld_i(fld_i), .kind_i(kind_i), .size_i(size_i), .ext_code_i(ext_code_i),
  .ext_val_i(ext_val_i), .quick_busy_i(quick_busy_i), .val_o(val_o),
  .bad_quick_o(bad_quick_o)
);

// File: tb/tb_qx_quick_expand.sv
module tb_qx_quick_expand;
  localparam int CLK_P = 10;
  localparam int PTR_W = 32;
  localparam int WDOG  = 20000;
  localparam int NV    = 34;

  typedef struct packed {
    logic [2:0]  kind;
    logic [7:0]  fld;
    logic [2:0]  size;
    logic [1:0]  ext;
    logic [63:0] ev;
    logic        busy;
    logic [63:0] exp_v;
    logic        exp_b;
    logic [23:0] tag;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{3'd0, 8'h00, 3'd3, 2'd0, 64'h0, 1'b0, 64'h8, 1'b0, "R1"},
    '{3'd0, 8'h0F, 3'd3, 2'd0, 64'h0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R1"},
    '{3'd0, 8'h08, 3'd3, 2'd0, 64'h0, 1'b0, 64'hFFFF_FFFF_FFFF_FFF8, 1'b0, "R1"},
    '{3'd0, 8'hF7, 3'd3, 2'd0, 64'h0, 1'b0, 64'h7, 1'b0, "R1"},
    '{3'd0, 8'h0F, 3'd0, 2'd0, 64'h0, 1'b0, 64'hFF, 1'b0, "R7"},
    '{3'd0, 8'h08, 3'd1, 2'd0, 64'h0, 1'b0, 64'hFFF8, 1'b0, "R7"},
    '{3'd0, 8'h0E, 3'd4, 2'd0, 64'h0, 1'b0, 64'hFFFF_FFFE, 1'b0, "R7"},
    '{3'd0, 8'h0F, 3'd5, 2'd0, 64'h0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R7"},
    '{3'd1, 8'h01, 3'd2, 2'd0, 64'h0, 1'b0, 64'h4, 1'b0, "R3"},
    '{3'd1, 8'h0F, 3'd3, 2'd0, 64'h0, 1'b0, 64'hFFFF_FFF8, 1'b0, "R3"},
    '{3'd1, 8'h00, 3'd7, 2'd0, 64'h0, 1'b0, 64'h200, 1'b0, "R3"},
    '{3'd1, 8'h03, 3'd4, 2'd0, 64'h0, 1'b0, 64'hC, 1'b0, "R3"},
    '{3'd1, 8'h02, 3'd6, 2'd0, 64'h0, 1'b0, 64'h40, 1'b0, "R3"},
    '{3'd1, 8'h0F, 3'd5, 2'd0, 64'h0, 1'b0, 64'hFFFF_FFF0, 1'b0, "R3"},
    '{3'd1, 8'h05, 3'd1, 2'd0, 64'h0, 1'b0, 64'hA, 1'b0, "R3"},
    '{3'd2, 8'h00, 3'd0, 2'd0, 64'h0, 1'b0, 64'h10, 1'b0, "R2"},
    '{3'd2, 8'h0F, 3'd3, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 64'hF, 1'b0, "R2"},
    '{3'd3, 8'h80, 3'd3, 2'd0, 64'h0, 1'b0, 64'hFFFF_FFFF_FFFF_FF80, 1'b0, "R4"},
    '{3'd4, 8'h80, 3'd7, 2'd0, 64'h0, 1'b0, 64'hFFFF_FF80, 1'b0, "R4"},
    '{3'd3, 8'h7F, 3'd2, 2'd0, 64'h0, 1'b0, 64'h7F, 1'b0, "R4"},
    '{3'd3, 8'h00, 3'd3, 2'd0, 64'h0, 1'b0, 64'h0, 1'b0, "R4"},
    '{3'd0, 8'h03, 3'd3, 2'd0, 64'h0, 1'b1, 64'h0, 1'b0, "R5"},
    '{3'd4, 8'h10, 3'd3, 2'd0, 64'h0, 1'b1, 64'h0, 1'b0, "R5"},
    '{3'd0, 8'h00, 3'd3, 2'd1, 64'h8001, 1'b0, 64'hFFFF_FFFF_FFFF_8001, 1'b0, "R6"},
    '{3'd3, 8'h00, 3'd3, 2'd2, 64'hAAAA_AAAA_8000_0000, 1'b0, 64'hFFFF_FFFF_8000_0000, 1'b0, "R6"},
    '{3'd3, 8'h00, 3'd3, 2'd3, 64'h1234_5678_9ABC_DEF0, 1'b0, 64'h1234_5678_9ABC_DEF0, 1'b0, "R6"},
    '{3'd0, 8'h00, 3'd0, 2'd1, 64'h1234, 1'b0, 64'h34, 1'b0, "R7"},
    '{3'd4, 8'h00, 3'd3, 2'd3, 64'h1234_5678_9ABC_DEF0, 1'b0, 64'h9ABC_DEF0, 1'b0, "R8"},
    '{3'd0, 8'h05, 3'd3, 2'd1, 64'h10, 1'b0, 64'h10, 1'b1, "R9"},
    '{3'd0, 8'h50, 3'd3, 2'd1, 64'h10, 1'b0, 64'h10, 1'b0, "R9"},
    '{3'd4, 8'h50, 3'd3, 2'd2, 64'h20, 1'b0, 64'h20, 1'b1, "R9"},
    '{3'd0, 8'h05, 3'd3, 2'd1, 64'h10, 1'b1, 64'h10, 1'b0, "R9"},
    '{3'd5, 8'h05, 3'd3, 2'd0, 64'h0, 1'b0, 64'h0, 1'b0, "R10"},
    '{3'd7, 8'hFF, 3'd3, 2'd1, 64'h10, 1'b0, 64'h0, 1'b0, "R10"}
  };

  logic        clk;
  logic        rst_n;
  logic [7:0]  fld_i;
  logic [2:0]  kind_i;
  logic [2:0]  size_i;
  logic [1:0]  ext_code_i;
  logic [63:0] ext_val_i;
  logic        quick_busy_i;
  logic [63:0] val_o;
  logic        bad_quick_o;
  int          n_chk;
  int          n_fail;
  int          cyc;

  qx_quick_expand #(.PTR_W(PTR_W)) dut (
    .fld_i(fld_i), .kind_i(kind_i), .size_i(size_i), .ext_code_i(ext_code_i),
    .ext_val_i(ext_val_i), .quick_busy_i(quick_busy_i), .val_o(val_o),
    .bad_quick_o(bad_quick_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= WDOG) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, cycles %0d expected below %0d", cyc, WDOG);
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic apply(input logic [2:0] k, input logic [7:0] f, input logic [2:0] s,
                       input logic [1:0] e, input logic [63:0] ev, input logic b);
    @(negedge clk);
    kind_i = k; fld_i = f; size_i = s; ext_code_i = e; ext_val_i = ev; quick_busy_i = b;
    #(CLK_P/4);
  endtask

  task automatic check(input string req, input logic [63:0] ev, input logic eb);
    n_chk = n_chk + 1;
    if (val_o !== ev || bad_quick_o !== eb) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: kind=%0d fld=%h size=%0d ext=%0d got val=%h bad=%b expected val=%h bad=%b",
               req, kind_i, fld_i, size_i, ext_code_i, val_o, bad_quick_o, ev, eb);
    end
  endtask

  initial begin
    n_chk = 0;
    n_fail = 0;
    rst_n = 1'b0;
    fld_i = '0; kind_i = '0; size_i = 3'd3; ext_code_i = '0; ext_val_i = '0; quick_busy_i = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // Idle state: IMM4 code 0000 at 64 bits reads +8 (R1)
    apply(3'd0, 8'h00, 3'd3, 2'd0, 64'h0, 1'b0);
    check("R1", 64'h8, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].kind, VECS[i].fld, VECS[i].size, VECS[i].ext, VECS[i].ev, VECS[i].busy);
      check(string'(VECS[i].tag), VECS[i].exp_v, VECS[i].exp_b);
    end

    // R1: every signed quick code at 64-bit width
    for (int c = 0; c < 16; c++) begin
      longint sv;
      sv = (c == 0) ? 8 : (c >= 8 ? c - 16 : c);
      apply(3'd0, 8'(c), 3'd3, 2'd0, 64'h0, 1'b0);
      check("R1", 64'(sv), 1'b0);
    end

    // R2: every scale code, extension and busy ignored
    for (int c = 0; c < 16; c++) begin
      apply(3'd2, 8'(c), 3'(c % 8), 2'(c % 4), 64'hDEAD_BEEF_0000_0001, c[0]);
      check("R2", (c == 0) ? 64'd16 : 64'(c), 1'b0);
    end

    // R3: offset code 0001 across all size codes gives the byte count
    for (int s = 0; s < 8; s++) begin
      int by;
      case (s)
        0: by = 1;  1: by = 2;  2: by = 4;  3: by = 8;
        4: by = PTR_W / 8;  5: by = 16;  6: by = 32;  default: by = 64;
      endcase
      apply(3'd1, 8'h01, 3'(s), 2'd0, 64'h0, 1'b0);
      check("R3", 64'(by), 1'b0);
    end

    // R8 corner: most negative scaled offset at largest size, masked to pointer
    apply(3'd1, 8'h08, 3'd7, 2'd0, 64'h0, 1'b0);
    check("R8", 64'hFFFF_FE00, 1'b0);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule